// File: doc/BRIEF.md
# Window Watchdog Timer

This block supervises a processor by checking how far apart the falling edges on its heartbeat input are. It measures the gap between successive falling edges in clock cycles. The gap must fall inside a window. An edge that comes too soon raises an early-edge fault. If no edge arrives before the upper bound, the block raises a late-edge fault. The upper bound is a programmed cycle count. The lower bound is that count divided by a power-of-two ratio, picked by two static strap pins. One strap combination switches the watchdog off.

A reset-pulse generator outside this block drives the reset-state input `sys_rst`. That generator holds the system in reset after either fault. While `sys_rst` is high, the timer stays at zero and heartbeat edges are ignored. Timing starts again when `sys_rst` is released. Each fault appears as a one-cycle strobe on its own pin and also on a combined pin.

There is no data stream here. Every pin is a plain level or strobe, and the block has no valid/ready handshake and no back-pressure.

Top module: `win_watchdog`

## Requirements
- R1: The strap pair (strap0, strap1) selects the mode. (0,0) gives ratio 8, (0,1) gives ratio 16 and (1,1) gives ratio 64. (1,0) turns the watchdog off: the timer is held at zero and no fault strobe is ever raised.
- R2: The early bound equals `slow_limit` shifted right by 3, 4 or 6 bits, for ratio 8, 16 or 64.
- R3: A falling edge seen while the timer count is below the early bound raises `fast_fault` for exactly one cycle and clears the timer.
- R4: If the count reaches `slow_limit` with no edge, `slow_fault` is raised for exactly one cycle and the timer clears.
- R5: A falling edge seen while the count is at least the early bound and below `slow_limit` is valid. It clears the timer and raises no fault.
- R6: While `sys_rst` is high, the timer is held at zero, edges are ignored and no fault is raised. Counting starts in the first cycle after release.
- R7: Any change in the strap pair clears the timer in the cycle the change is first seen. No fault is evaluated in that cycle.
- R8: `fault` is high exactly when `fast_fault` or `slow_fault` is high, and those two are never high together.
- R9: `wdi` passes through `SYNC_STAGES` synchronizer flops. A falling edge is evaluated at the clock edge after the synchronizer's last stage captures the low level. The resulting strobe is registered and visible one cycle after that evaluation.
- R10: While `rst_n` is low, all outputs are low. After any fault, the timer restarts from zero and counts up by one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's flops |
| sys_rst | input | 1 | High while the supervised system is held in reset |
| wdi | input | 1 | Heartbeat input; its falling edges are checked |
| strap0 | input | 1 | Window-ratio strap, first bit |
| strap1 | input | 1 | Window-ratio strap, second bit |
| slow_limit | input | CW | Upper window bound in clock cycles |
| fast_fault | output | 1 | One-cycle strobe: edge came too early |
| slow_fault | output | 1 | One-cycle strobe: no edge in time |
| fault | output | 1 | One-cycle strobe: either fault |

## Verification
A falling level on `wdi` driven between edges reaches the window comparison after `SYNC_STAGES` plus one clock edges. Its strobe becomes visible after one more edge. A late-edge strobe appears one edge after the count reaches `slow_limit`. A strap change or a `sys_rst` level takes effect on the timer at the very next edge. The bench steps a behavioural model at each rising edge with these same delays. It compares all three outputs at every falling edge, so each result is checked in the cycle it is due and in every cycle around it.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

  typedef enum logic [1:0] {
    WIN_R8  = 2'd0,
    WIN_R16 = 2'd1,
    WIN_R64 = 2'd2,
    WIN_OFF = 2'd3
  } win_mode_e;

  // Strap pair (first, second) to window mode.
  function automatic win_mode_e decode_straps(input logic s_first, input logic s_second);
    case ({s_first, s_second})
      2'b00:   return WIN_R8;
      2'b01:   return WIN_R16;
      2'b11:   return WIN_R64;
      default: return WIN_OFF;
    endcase
  endfunction

  // Right-shift that turns the upper bound into the early bound.
  function automatic int unsigned mode_shift(input win_mode_e m);
    case (m)
      WIN_R8:  return 3;
      WIN_R16: return 4;
      WIN_R64: return 6;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/wdw_sync_fall.sv
module wdw_sync_fall #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);

  logic level;
  logic level_q;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign level = din;
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain <= '1;
        end else begin
          chain <= {chain[SYNC_STAGES-2+((SYNC_STAGES==1)?1:0):0], din} ;
        end
      end
      assign level = chain[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b1;
    else        level_q <= level;
  end

  assign fall = level_q & ~level;

  AST_FALL_NEEDS_HIGH_BEFORE: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall); // R9

endmodule

// File: rtl/wdw_limits.sv
module wdw_limits
  import wdw_pkg::*;
#(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap0,
  input  logic          strap1,
  input  logic [CW-1:0] slow_limit,
  output logic [CW-1:0] fast_limit,
  output logic          off,
  output logic          strap_changed
);

  win_mode_e   mode;
  logic [1:0]  strap_q;
  int unsigned shamt;

  always_comb begin
    mode       = decode_straps(strap0, strap1);
    shamt      = mode_shift(mode);
    off        = (mode == WIN_OFF);
    fast_limit = slow_limit >> shamt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strap_q <= 2'b00;
    else        strap_q <= {strap0, strap1};
  end

  assign strap_changed = (strap_q != {strap0, strap1});

  AST_EARLY_NOT_ABOVE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    !off |-> (fast_limit <= slow_limit)); // R2

endmodule

// File: rtl/wdw_window_timer.sv
module wdw_window_timer #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          fall,
  input  logic [CW-1:0] fast_limit,
  input  logic [CW-1:0] slow_limit,
  output logic          early_evt,
  output logic          late_evt,
  output logic          early_q,
  output logic          late_q
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_n;

  always_comb begin
    early_evt = 1'b0;
    late_evt  = 1'b0;
    cnt_n     = cnt + 1'b1;
    if (hold) begin
      cnt_n = '0;
    end else if (cnt >= slow_limit) begin
      late_evt = 1'b1;
      cnt_n    = '0;
    end else if (fall) begin
      early_evt = (cnt < fast_limit);
      cnt_n     = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      early_q <= 1'b0;
      late_q  <= 1'b0;
    end else begin
      cnt     <= cnt_n;
      early_q <= early_evt;
      late_q  <= late_evt;
    end
  end

  AST_HOLD_ZEROES_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt == '0)); // R6

  AST_RESTART_AFTER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (early_q || late_q) |-> (cnt == '0)); // R10

  AST_NO_DOUBLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(early_q && late_q)); // R8

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int CW          = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_rst,
  input  logic          wdi,
  input  logic          strap0,
  input  logic          strap1,
  input  logic [CW-1:0] slow_limit,
  output logic          fast_fault,
  output logic          slow_fault,
  output logic          fault
);

  logic          fall;
  logic [CW-1:0] fast_limit;
  logic          off;
  logic          strap_changed;
  logic          hold;
  logic          early_evt;
  logic          late_evt;

  wdw_sync_fall #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (wdi),
    .fall (fall)
  );

  wdw_limits #(.CW(CW)) u_limits (
    .clk          (clk),
    .rst_n        (rst_n),
    .strap0       (strap0),
    .strap1       (strap1),
    .slow_limit   (slow_limit),
    .fast_limit   (fast_limit),
    .off          (off),
    .strap_changed(strap_changed)
  );

  assign hold = sys_rst | off | strap_changed;

  wdw_window_timer #(.CW(CW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (hold),
    .fall      (fall),
    .fast_limit(fast_limit),
    .slow_limit(slow_limit),
    .early_evt (early_evt),
    .late_evt  (late_evt),
    .early_q   (fast_fault),
    .late_q    (slow_fault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault <= 1'b0;
    else        fault <= early_evt | late_evt;
  end

  AST_COMBINED_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    fault == (fast_fault || slow_fault)); // R8

  AST_QUIET_IN_SYS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !fault); // R6

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (strap0 && !strap1) |=> !fault); // R1

  AST_STRAP_EDGE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    strap_changed |=> !fault); // R7

endmodule

// File: tb/win_watchdog_test.sv
module win_watchdog_test;

  localparam int CW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sys_rst = 1'b1;
  logic          wdi = 1'b1;
  logic          strap0 = 1'b0;
  logic          strap1 = 1'b0;
  logic [CW-1:0] slow_limit = 24'd200;
  logic          fast_fault, slow_fault, fault;

  win_watchdog #(.CW(CW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .wdi(wdi),
    .strap0(strap0), .strap1(strap1), .slow_limit(slow_limit),
    .fast_fault(fast_fault), .slow_fault(slow_fault), .fault(fault)
  );

  always #2.5 clk = ~clk;

  int    n_vec = 0;
  int    n_bad = 0;
  int    n_cyc = 0;
  string tag = "R10";

  // Behavioural reference model
  int m_s1 = 1, m_s2 = 1, m_prev = 1;
  int m_cnt = 0;
  int m_sq = 0;
  int m_ff = 0, m_sf = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_prev = 1; m_cnt = 0; m_sq = 0; m_ff = 0; m_sf = 0;
    end else begin
      int st, sh, lim, early;
      bit is_fall, is_off;
      st      = {strap0, strap1};
      is_fall = (m_prev == 1) && (m_s2 == 0);
      is_off  = (st == 2);
      sh      = (st == 0) ? 3 : (st == 1) ? 4 : 6;
      lim     = int'(slow_limit);
      early   = lim / (1 << sh);
      m_ff = 0; m_sf = 0;
      if (sys_rst || is_off || st != m_sq) m_cnt = 0;
      else if (m_cnt >= lim) begin m_sf = 1; m_cnt = 0; end
      else if (is_fall) begin
        if (m_cnt < early) m_ff = 1;
        m_cnt = 0;
      end else m_cnt = m_cnt + 1;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = int'(wdi); m_sq = st;
    end
  end

  task automatic summary_and_end();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    n_cyc++;
    n_vec++;
    if (fast_fault !== m_ff[0] || slow_fault !== m_sf[0] ||
        fault !== (m_ff[0] | m_sf[0])) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual fast/slow/fault=%b%b%b expected %b%b%b",
               tag, n_cyc, fast_fault, slow_fault, fault,
               m_ff[0], m_sf[0], m_ff[0] | m_sf[0]);
    end
    if (n_cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired: actual running expected done");
      summary_and_end();
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Falling edge on wdi, next edge `gap` cycles later
  task automatic beat(input int gap);
    wdi = 1'b0; tick(2);
    wdi = 1'b1; tick(gap - 2);
  endtask

  initial begin
    // R10: flop reset holds every output low
    tag = "R10";
    tick(4);
    rst_n = 1'b1;
    // R6: edges during system reset are ignored
    tag = "R6";
    tick(3);
    beat(5); beat(4); beat(30);
    sys_rst = 1'b0;
    tick(3);
    // R5: edges comfortably inside the window (early bound 25)
    tag = "R5";
    beat(60); beat(60); beat(100); beat(150);
    // R3: edges too close together
    tag = "R3";
    beat(10); beat(8); beat(60);
    // R2: gaps straddling the early bound of 200>>3
    tag = "R2";
    beat(24); beat(25); beat(26); beat(27); beat(24); beat(60);
    // R4: long silence gives repeated late faults; R10 restart spacing
    tag = "R4";
    tick(450);
    beat(60);
    // R1: other ratios and the off mode
    tag = "R1";
    strap1 = 1'b1; tick(3);
    beat(14); beat(11); beat(20); beat(60);
    strap0 = 1'b1; tick(3);
    beat(4); beat(2); beat(5); beat(60);
    strap1 = 1'b0; tick(3);
    beat(3); beat(3); tick(400);
    // R7: strap changes restart the timer
    tag = "R7";
    strap0 = 1'b0; tick(150);
    strap1 = 1'b1; tick(1); strap1 = 1'b0; tick(150);
    strap1 = 1'b1; tick(120); strap1 = 1'b0; tick(250);
    // R9: smaller limit, single edges near both bounds
    tag = "R9";
    slow_limit = 24'd40;
    tick(60);
    beat(4); beat(5); beat(6); beat(38); beat(41); tick(90);
    // R8: mix of both fault kinds with the combined output
    tag = "R8";
    beat(3); beat(45); beat(20); tick(100);
    // R6 again: system reset mid-window
    tag = "R6";
    tick(20); sys_rst = 1'b1; beat(3); tick(10); sys_rst = 1'b0;
    beat(10); tick(60);
    // R10: flop reset mid-run
    tag = "R10";
    rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(60);
    summary_and_end();
  end

endmodule